// File: doc/BRIEF.md
# Packet Buffer with Whole-Message Drop

This block is a single-clock store-and-forward FIFO for a packet datapath. Each storage entry is 36 bits wide. It holds a 32-bit data word and four sideband bits: an end-of-message marker, a 2-bit count of valid bytes, and a discard flag. Words arrive on a write-side stream that has no back-pressure. The read side is a valid/ready stream that carries the data and the same sideband.

Incoming words are written at a speculative pointer. They become visible to the reader only when the final word of their message arrives without the discard flag. At that point a committed pointer jumps forward to the speculative one. A discarded message is removed by moving the speculative pointer back to the committed pointer, so the reader never sees any of its words. When storage runs out partway through a message, that message is dropped in the same way. Its remaining words are then ignored up to its final word.

Top module: `pkt_drop_fifo`

## Requirements
- R1: Every delivered word carries the data, end-of-message bit and byte count that were written for it. Words are delivered in write order. The byte count is 2 bits, where 0 means four bytes and 1 to 3 mean that many bytes. It is meaningful on the final word only.
- R2: No word of a message is offered to the reader until that message's final word (`s_last`=1, `s_abort`=0) has been accepted. `m_valid` rises no later than the second clock edge after the edge that accepts that final word, provided the output stage is empty.
- R3: A word with `s_abort`=1 ends the current message and discards it, including that word itself, whatever the value of `s_last`. The buffer then holds exactly what it held before that message began.
- R4: Storage holds 2^ADDR_W words plus one word in the output stage. If a word arrives while storage is full, the current message is dropped as in R3. If that word is not final, the following words are ignored up to and including the next word with `s_last` or `s_abort` set. The next message is then accepted normally.
- R5: `m_valid` stays high while committed words remain. A word leaves only on a clock edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data`, `m_last` and `m_nbytes` hold steady.
- R6: `m_abort` is 0 on every word offered to the reader.
- R7: On the cycle after `rst` is sampled high, `m_valid` is 0 and the buffer is empty.
- R8: A cycle with `s_valid` low changes nothing on the write side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Write word present |
| s_data | input | 32 | Write data |
| s_last | input | 1 | Final word of message |
| s_nbytes | input | 2 | Valid bytes on final word (0 means 4) |
| s_abort | input | 1 | Discard the current message |
| m_valid | output | 1 | Read word available |
| m_ready | input | 1 | Reader accepts word |
| m_data | output | 32 | Read data |
| m_last | output | 1 | Final word of delivered message |
| m_nbytes | output | 2 | Valid bytes on delivered final word |
| m_abort | output | 1 | Discard bit of delivered word, always 0 |

## Verification
The assertions assume that `rst` is high from time zero for at least one edge. They also assume that `m_ready` is a free input that may drop at any time. They assume nothing about the write side, because any pattern of `s_valid`, `s_last` and `s_abort` is legal, including discard on a non-final word and discard while a message is already being dropped. The stimulus therefore drives `m_ready` either held or from a shift-register pattern. It also mixes idle cycles between writes and builds the overflow cases from messages sized from the storage depth, so that both the final-word drop and the mid-message drop occur.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic              abort;
    logic              last;
    logic [CNT_W-1:0]  nbytes;
    logic [DATA_W-1:0] data;
  } pdf_word_t;

  localparam int WORD_W = $bits(pdf_word_t);
endpackage

// File: rtl/pdf_ram.sv
module pdf_ram #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pdf_wr_ctrl.sv
module pdf_wr_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  input  logic            s_last,
  input  logic            s_abort,
  input  logic [ADDR_W:0] rd_ptr,
  output logic            we,
  output logic [ADDR_W:0] spec_ptr,
  output logic [ADDR_W:0] commit_ptr
);
  logic            dropping;
  logic [ADDR_W:0] occ;
  logic            full;

  // occupancy never exceeds 2^ADDR_W, so its top bit alone flags full
  assign occ  = spec_ptr - rd_ptr;
  assign full = occ[ADDR_W];

  always_comb we = s_valid && !dropping && !s_abort && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_ptr   <= '0;
      commit_ptr <= '0;
      dropping   <= 1'b0;
    end else if (s_valid) begin
      if (dropping) begin
        if (s_last || s_abort) dropping <= 1'b0;
      end else if (s_abort) begin
        spec_ptr <= commit_ptr;
      end else if (full) begin
        spec_ptr <= commit_ptr;
        dropping <= !s_last;
      end else begin
        spec_ptr <= spec_ptr + 1'b1;
        if (s_last) commit_ptr <= spec_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdf_rd_ctrl.sv
module pdf_rd_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W:0] commit_ptr,
  input  logic            m_ready,
  output logic            re,
  output logic [ADDR_W:0] rd_ptr,
  output logic            m_valid
);
  logic have_word;

  assign have_word = rd_ptr != commit_ptr;
  always_comb re = have_word && (!m_valid || m_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      m_valid <= 1'b0;
    end else if (re) begin
      rd_ptr  <= rd_ptr + 1'b1;
      m_valid <= 1'b1;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_drop_fifo.sv
module pkt_drop_fifo
  import pdf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic [CNT_W-1:0]  s_nbytes,
  input  logic              s_abort,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_last,
  output logic [CNT_W-1:0]  m_nbytes,
  output logic              m_abort
);
  logic            we, re;
  logic [ADDR_W:0] spec_ptr, commit_ptr, rd_ptr;
  pdf_word_t       wword, rword;

  assign wword = '{abort: s_abort, last: s_last, nbytes: s_nbytes, data: s_data};

  pdf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_abort    (s_abort),
    .rd_ptr     (rd_ptr),
    .we         (we),
    .spec_ptr   (spec_ptr),
    .commit_ptr (commit_ptr)
  );

  pdf_ram #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (spec_ptr[ADDR_W-1:0]),
    .wdata (wword),
    .re    (re),
    .raddr (rd_ptr[ADDR_W-1:0]),
    .rdata (rword)
  );

  pdf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .commit_ptr (commit_ptr),
    .m_ready    (m_ready),
    .re         (re),
    .rd_ptr     (rd_ptr),
    .m_valid    (m_valid)
  );

  assign m_data   = rword.data;
  assign m_last   = rword.last;
  assign m_nbytes = rword.nbytes;
  assign m_abort  = rword.abort;
endmodule

// File: rtl/pdf_chk.sv
module pdf_chk #(
  parameter int ADDR_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            s_valid,
  input logic            s_abort,
  input logic            m_valid,
  input logic            m_ready,
  input logic [31:0]     m_data,
  input logic            m_last,
  input logic [1:0]      m_nbytes,
  input logic            m_abort,
  input logic [ADDR_W:0] spec_ptr,
  input logic [ADDR_W:0] commit_ptr,
  input logic [ADDR_W:0] rd_ptr
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(1 << ADDR_W);

  logic [ADDR_W:0] occ;
  assign occ = spec_ptr - rd_ptr;

  // R7
  rst_empty_chk: assert property (@(posedge clk) rst |=> !m_valid);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last) && $stable(m_nbytes));

  // R6
  no_abort_out_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !m_abort);

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CAP);

  // R3
  abort_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    s_valid && s_abort |=> spec_ptr == commit_ptr);

  // R2
  visible_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(commit_ptr != rd_ptr));
endmodule

bind pkt_drop_fifo pdf_chk #(.ADDR_W(ADDR_W)) u_pdf_chk (
  .clk        (clk),
  .rst        (rst),
  .s_valid    (s_valid),
  .s_abort    (s_abort),
  .m_valid    (m_valid),
  .m_ready    (m_ready),
  .m_data     (m_data),
  .m_last     (m_last),
  .m_nbytes   (m_nbytes),
  .m_abort    (m_abort),
  .spec_ptr   (spec_ptr),
  .commit_ptr (commit_ptr),
  .rd_ptr     (rd_ptr)
);

// File: tb/test_pkt_drop_fifo.sv
`timescale 1ns/1ps
module test_pkt_drop_fifo;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 14;

  // {keep, last, abort, nbytes[1:0], data[31:0]}
  localparam logic [36:0] TBL [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 2'd0, 32'h1111_0001},
    {1'b1, 1'b1, 1'b0, 2'd3, 32'h1111_0002},
    {1'b0, 1'b0, 1'b0, 2'd0, 32'h2222_0001},
    {1'b0, 1'b0, 1'b0, 2'd0, 32'h2222_0002},
    {1'b0, 1'b1, 1'b1, 2'd2, 32'h2222_0003},
    {1'b1, 1'b1, 1'b0, 2'd1, 32'h3333_0001},
    {1'b0, 1'b0, 1'b0, 2'd0, 32'h4444_0001},
    {1'b0, 1'b0, 1'b1, 2'd0, 32'h4444_0002},
    {1'b1, 1'b0, 1'b0, 2'd0, 32'h5555_0001},
    {1'b1, 1'b0, 1'b0, 2'd0, 32'h5555_0002},
    {1'b1, 1'b1, 1'b0, 2'd2, 32'h5555_0003},
    {1'b0, 1'b1, 1'b1, 2'd1, 32'h6666_0001},
    {1'b1, 1'b0, 1'b0, 2'd0, 32'h7777_0001},
    {1'b1, 1'b1, 1'b0, 2'd0, 32'h7777_0002}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0, s_last = 1'b0, s_abort = 1'b0;
  logic [31:0] s_data = '0;
  logic [1:0]  s_nbytes = '0;
  logic        m_valid, m_ready, m_last, m_abort;
  logic [31:0] m_data;
  logic [1:0]  m_nbytes;

  int checks = 0;
  int fails  = 0;
  int rd_mode = 0;   // 0 hold low, 1 pattern, 2 always high
  bit done = 0;
  logic [34:0] exp_q [$];
  logic [7:0]  lfsr = 8'hA5;

  always #4 clk = ~clk;

  pkt_drop_fifo #(.ADDR_W(ADDR_W)) i_pkt_drop_fifo (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_nbytes(s_nbytes), .s_abort(s_abort), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_nbytes(m_nbytes), .m_abort(m_abort)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic last, input logic abort, input logic [1:0] nb, input logic [31:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_last = last; s_abort = abort; s_nbytes = nb; s_data = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0; s_abort = 1'b0;
    end
  endtask

  // message of n words; final word carries nb; optionally expected at reader
  task automatic send_msg(input logic [15:0] tag, input int n, input logic [1:0] nb, input bit keep);
    for (int k = 0; k < n; k++) begin
      logic lst;
      lst = (k == n - 1);
      if (keep) exp_q.push_back({lst, lst ? nb : 2'd0, tag, 16'(k)});
      send(lst, 1'b0, lst ? nb : 2'd0, {tag, 16'(k)});
    end
    idle(1);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    idle(4);
  endtask

  // reader and output checker
  initial begin
    m_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (rd_mode)
        0: m_ready = 1'b0;
        1: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          m_ready = lfsr[0];
        end
        default: m_ready = 1'b1;
      endcase
      #1;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected word", 64'({m_last, m_nbytes, m_data}), 64'd0);
        end else begin
          logic [34:0] e;
          e = exp_q.pop_front();
          chk({m_last, m_nbytes, m_data} == e, "R1 word content/order",
              64'({m_last, m_nbytes, m_data}), 64'(e));
          chk(m_abort == 1'b0, "R6 abort bit on output", 64'(m_abort), 64'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(m_valid == 1'b0, "R7 reset m_valid", 64'(m_valid), 64'd0);

    // table walk: R1 R3 R8 with patterned ready
    rd_mode = 1;
    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i][36]) exp_q.push_back({TBL[i][35], TBL[i][33:32], TBL[i][31:0]});
      send(TBL[i][35], TBL[i][34], TBL[i][33:32], TBL[i][31:0]);
      if (i % 3 == 2) idle(1);   // R8 gap
    end
    idle(1);
    drain();
    chk(m_valid == 1'b0, "R3 discarded words left nothing", 64'(m_valid), 64'd0);

    // R2: partial message stays hidden
    rd_mode = 2;
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back({1'b0, 2'd0, 16'hABCD, 16'(k)});
      send(1'b0, 1'b0, 2'd0, {16'hABCD, 16'(k)});
    end
    idle(6);
    chk(m_valid == 1'b0, "R2 partial message hidden", 64'(m_valid), 64'd0);
    exp_q.push_back({1'b1, 2'd2, 16'hABCD, 16'd3});
    send(1'b1, 1'b0, 2'd2, {16'hABCD, 16'd3});
    idle(1);                       // one edge: commit
    @(negedge clk); #2;            // second edge: output loaded
    chk(m_valid == 1'b1, "R2 visible two edges after final word", 64'(m_valid), 64'd1);
    drain();

    // R4: overflow with reader stalled
    rd_mode = 0;
    send_msg(16'hA000, 4, 2'd1, 1'b1);
    idle(5);
    send_msg(16'hB000, DEPTH - 2, 2'd0, 1'b0);  // final word meets full: dropped
    send_msg(16'hC000, 2, 2'd3, 1'b1);
    send_msg(16'hD000, DEPTH, 2'd0, 1'b0);      // full mid-message, tail ignored
    send_msg(16'hE000, 1, 2'd2, 1'b1);
    idle(3);
    begin
      logic [31:0] held;
      held = m_data;
      chk(m_valid == 1'b1, "R5 valid held while stalled", 64'(m_valid), 64'd1);
      idle(3); #2;
      chk(m_data == held, "R5 data stable while stalled", 64'(m_data), 64'(held));
      chk(held == 32'hA000_0000, "R4 first kept word", 64'(held), 64'hA000_0000);
    end
    rd_mode = 2;
    drain();
    chk(exp_q.size() == 0, "R4 all kept messages delivered", 64'(exp_q.size()), 64'd0);
    #2;
    chk(m_valid == 1'b0, "R5 valid low when empty", 64'(m_valid), 64'd0);

    // R7: reset mid-stream empties the buffer
    rd_mode = 0;
    send_msg(16'hF000, 2, 2'd0, 1'b0);
    idle(3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #2;
    chk(m_valid == 1'b0, "R7 reset clears buffer", 64'(m_valid), 64'd0);
    rd_mode = 2;
    idle(5); #2;
    chk(m_valid == 1'b0, "R7 nothing after reset", 64'(m_valid), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule